// File: doc/BRIEF.md
# Dual-Nibble DRAM Access Sequencer

This block shares one nibble-wide DRAM between a video fetch engine and a CPU. Time is cut into slots of eight clocks. A one-hot ring steps through the eight phases of a slot. In each slot one byte is fetched as two 4-bit column reads under a single row selection, with the high nibble read first. At the start of a slot the block decides who owns it. Video wins only when the non-maskable interrupt line is quiet, the slot counter is at zero and the video engine says the beam needs data. In every other case the CPU address drives the whole slot.

A completed video byte is offered on a valid/ready output. The DRAM cycle cannot stall, so back-pressure does not pause the sequencer. A byte that has not been accepted stays on the output, unchanged, until it is taken. If the next video byte lands first, it replaces the old one. The consumer must therefore accept each byte before the next video slot reaches phase 6. A one-clock column-advance pulse tells the video address generator to move to its next column. CPU reads return a byte together with a one-clock valid pulse. The slot counter sets the video share: one slot in 1, 2 or 4.

Top module: `nibble_dram_seq`

## Requirements
- R1: After reset the phase ring sits in phase 7. The first clock moves it to phase 0. Each clock after that advances it by one phase, and it wraps from phase 7 back to phase 0.
- R2: For the slot address `a`, `dram_addr` carries the following values. In phase 0 it is the row `a[15:7]`. In phases 1 to 3 it is the first column `{a[6:0],0}`. In phases 4 to 6 it is the second column `{a[6:0],1}`. Upper bits are zero.
- R3: `row_sel` is high in exactly phases 1 to 6 of every slot. `col_sel` is high in exactly phases 2, 3, 5 and 6.
- R4: The assembled byte takes `dram_dq` from phase 2 as its high nibble (bits 7:4) and `dram_dq` from phase 5 as its low nibble.
- R5: On entry to phase 0 the owner is decided. The slot is video when `nmi_active` is 0, `vid_want` is 1 and the slot counter is 0. Otherwise it is a CPU slot. Address, owner and read request are held for all eight phases, and input changes during the slot are ignored.
- R6: The slot counter advances on entry to phase 7 and wraps modulo the access frequency. The frequency is 2 or 4 as given; any other value of `acc_freq` acts as 1. `acc_freq` is sampled only on entry to phase 7.
- R7: A video slot loads `vid_byte` and sets `vid_valid` on entry to phase 6. `col_adv` is high for that one clock only.
- R8: While `vid_valid` is 1 and `vid_ready` is 0, `vid_valid` and `vid_byte` hold. A handshake clears `vid_valid` at the next clock. A new video byte takes priority and overwrites.
- R9: A CPU slot with `cpu_rd` set loads `cpu_data` on entry to phase 6 and pulses `cpu_valid` for one clock. Without `cpu_rd`, or in a video slot, `cpu_data` is unchanged and `cpu_valid` stays 0.
- R10: During reset `row_sel`, `col_sel`, `col_adv`, `vid_valid` and `cpu_valid` are 0, and `dram_addr` is 0. The slot counter restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_addr | input | 16 | Byte address wanted by the video engine |
| vid_want | input | 1 | Beam is in the pixel area and not on a spacing line |
| nmi_active | input | 1 | Non-maskable interrupt active; blocks video slots |
| cpu_addr | input | 16 | CPU byte address |
| cpu_rd | input | 1 | CPU read request |
| acc_freq | input | 3 | Video slot share: 1, 2 or 4 |
| dram_dq | input | 4 | Nibble returned by the DRAM |
| dram_addr | output | 9 | Multiplexed row/column address |
| row_sel | output | 1 | Row select strobe, active high |
| col_sel | output | 1 | Column select strobe, active high |
| col_adv | output | 1 | One-clock pulse: video column done |
| vid_byte | output | 8 | Assembled video byte |
| vid_valid | output | 1 | Video byte valid |
| vid_ready | input | 1 | Consumer accepts video byte |
| cpu_data | output | 8 | Last CPU read byte |
| cpu_valid | output | 1 | One-clock pulse: new CPU byte |

## Verification
The hardest behaviour to reach is the claim that inputs are ignored mid-slot, along with the late sampling of the frequency. The ports only show the result several clocks after the decision. To reach it, every slot in the stimulus table inverts all arbitration inputs, addresses and the frequency code from phase 2 to phase 5 and restores them at phase 6. The strobes, address and data then show whether anything leaked. Overwrite under back-pressure is reached by holding `vid_ready` low across two back-to-back video slots.

// File: rtl/nds_pkg.sv
package nds_pkg;
  localparam int PHASES  = 8;
  localparam int NIB_W   = 4;
  localparam int FREQ_W  = 3;
  localparam int MAX_FREQ = 4;

  // phase indices where the sequencer acts
  localparam int PH_ROW   = 0;
  localparam int PH_COL0  = 1;
  localparam int PH_STB0  = 2;
  localparam int PH_HI    = 3;
  localparam int PH_COL1  = 4;
  localparam int PH_STB1  = 5;
  localparam int PH_LO    = 6;
  localparam int PH_CLOSE = 7;

  function automatic logic [FREQ_W-1:0] eff_freq(input logic [FREQ_W-1:0] f);
    if (f == FREQ_W'(2) || f == FREQ_W'(4)) return f;
    return FREQ_W'(1);
  endfunction
endpackage

// File: rtl/nds_phase_ring.sv
module nds_phase_ring #(
  parameter int N = nds_pkg::PHASES
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [N-1:0] ph,
  output logic [N-1:0] ph_nxt
);
  assign ph_nxt = {ph[N-2:0], ph[N-1]};

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= {1'b1, {(N-1){1'b0}}};
    else        ph <= ph_nxt;
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ph) == 1);
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    ph[N-1] |=> ph[0]);
endmodule

// File: rtl/nds_slot_arbiter.sv
module nds_slot_arbiter #(
  parameter int ADDR_W = 16,
  parameter int N      = nds_pkg::PHASES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N-1:0]                ph_nxt,
  input  logic                        nmi_active,
  input  logic                        vid_want,
  input  logic [ADDR_W-1:0]           vid_addr,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic                        cpu_rd,
  input  logic [nds_pkg::FREQ_W-1:0]  acc_freq,
  output logic [ADDR_W-1:0]           next_addr,
  output logic [ADDR_W-1:0]           slot_addr,
  output logic                        slot_vid,
  output logic                        slot_rd
);
  import nds_pkg::*;
  localparam int CNT_W = $clog2(MAX_FREQ);

  logic [CNT_W-1:0]  acc_cnt;
  logic              take_vid;
  logic [FREQ_W-1:0] cnt_inc;
  logic [FREQ_W-1:0] freq_e;

  always_comb begin
    take_vid  = !nmi_active && vid_want && (acc_cnt == '0);
    next_addr = take_vid ? vid_addr : cpu_addr;
    freq_e    = eff_freq(acc_freq);
    cnt_inc   = FREQ_W'(acc_cnt) + FREQ_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_vid  <= 1'b0;
      slot_addr <= '0;
      slot_rd   <= 1'b0;
    end else if (ph_nxt[PH_ROW]) begin
      slot_vid  <= take_vid;
      slot_addr <= next_addr;
      slot_rd   <= !take_vid && cpu_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_cnt <= '0;
    else if (ph_nxt[PH_CLOSE])
      acc_cnt <= (cnt_inc >= freq_e) ? '0 : CNT_W'(cnt_inc);
  end

  a_r5_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_nxt[PH_ROW] |=> $stable(slot_addr) && $stable(slot_vid) && $stable(slot_rd));
  a_r6_cnt_only_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_nxt[PH_CLOSE] |=> $stable(acc_cnt));
  a_r5_vid_not_rd: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vid |-> !slot_rd);
endmodule

// File: rtl/nds_addr_strobe.sv
module nds_addr_strobe #(
  parameter int ADDR_W   = 16,
  parameter int COL_BITS = 7,
  parameter int N        = nds_pkg::PHASES,
  parameter int DA_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      ph_nxt,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic [ADDR_W-1:0] slot_addr,
  output logic [DA_W-1:0]   dram_addr,
  output logic              row_sel,
  output logic              col_sel
);
  import nds_pkg::*;
  localparam int ROW_W = ADDR_W - COL_BITS;

  logic [DA_W-1:0] row_v, col0_v, col1_v;

  always_comb begin
    row_v  = DA_W'(next_addr[ADDR_W-1:COL_BITS]);
    col0_v = DA_W'({slot_addr[COL_BITS-1:0], 1'b0});
    col1_v = DA_W'({slot_addr[COL_BITS-1:0], 1'b1});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dram_addr <= '0;
    else if (ph_nxt[PH_ROW])  dram_addr <= row_v;
    else if (ph_nxt[PH_COL0]) dram_addr <= col0_v;
    else if (ph_nxt[PH_COL1]) dram_addr <= col1_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) row_sel <= 1'b0;
    else if (ph_nxt[PH_COL0])  row_sel <= 1'b1;
    else if (ph_nxt[PH_CLOSE]) row_sel <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) col_sel <= 1'b0;
    else if (ph_nxt[PH_STB0] || ph_nxt[PH_STB1]) col_sel <= 1'b1;
    else if (ph_nxt[PH_COL1] || ph_nxt[PH_CLOSE]) col_sel <= 1'b0;
  end

  a_r3_row_open_at_col: assert property (@(posedge clk) disable iff (!rst_n)
    ph_nxt[PH_STB0] |=> row_sel && col_sel);
  a_r2_addr_hold_under_col: assert property (@(posedge clk) disable iff (!rst_n)
    (col_sel && !ph_nxt[PH_COL1] && !ph_nxt[PH_CLOSE]) |=> $stable(dram_addr));
endmodule

// File: rtl/nds_byte_assembler.sv
module nds_byte_assembler #(
  parameter int N      = nds_pkg::PHASES,
  parameter int NIB_W  = nds_pkg::NIB_W,
  parameter int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      ph_nxt,
  input  logic [NIB_W-1:0]  dram_dq,
  input  logic              slot_vid,
  input  logic              slot_rd,
  input  logic              vid_ready,
  output logic [BYTE_W-1:0] vid_byte,
  output logic              vid_valid,
  output logic              col_adv,
  output logic [BYTE_W-1:0] cpu_data,
  output logic              cpu_valid
);
  import nds_pkg::*;

  logic [NIB_W-1:0]  hi_q;
  logic [BYTE_W-1:0] word;
  logic              done;

  assign word = {hi_q, dram_dq};
  assign done = ph_nxt[PH_LO];

  always_ff @(posedge clk) begin
    if (!rst_n) hi_q <= '0;
    else if (ph_nxt[PH_HI]) hi_q <= dram_dq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vid_byte  <= '0;
      vid_valid <= 1'b0;
      col_adv   <= 1'b0;
    end else begin
      col_adv <= done && slot_vid;
      if (done && slot_vid) begin
        vid_byte  <= word;
        vid_valid <= 1'b1;
      end else if (vid_valid && vid_ready) begin
        vid_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_data  <= '0;
      cpu_valid <= 1'b0;
    end else begin
      cpu_valid <= done && slot_rd;
      if (done && slot_rd) cpu_data <= word;
    end
  end

  a_r7_adv_single: assert property (@(posedge clk) disable iff (!rst_n)
    col_adv |=> !col_adv);
  a_r7_adv_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    col_adv |-> vid_valid);
  a_r8_hold_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_valid && !vid_ready && !(done && slot_vid)) |=> vid_valid && $stable(vid_byte));
  a_r9_cpu_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |=> !cpu_valid);
  a_r9_owner_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(col_adv && cpu_valid));
  a_r9_cpu_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && slot_rd) |=> $stable(cpu_data));
endmodule

// File: rtl/nibble_dram_seq.sv
module nibble_dram_seq #(
  parameter int ADDR_W   = 16,
  parameter int COL_BITS = 7,
  parameter int NIB_W    = nds_pkg::NIB_W,
  parameter int DA_W     = ((ADDR_W - COL_BITS) > (COL_BITS + 1)) ?
                           (ADDR_W - COL_BITS) : (COL_BITS + 1),
  parameter int BYTE_W   = 2 * NIB_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          vid_addr,
  input  logic                       vid_want,
  input  logic                       nmi_active,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic                       cpu_rd,
  input  logic [nds_pkg::FREQ_W-1:0] acc_freq,
  input  logic [NIB_W-1:0]           dram_dq,
  output logic [DA_W-1:0]            dram_addr,
  output logic                       row_sel,
  output logic                       col_sel,
  output logic                       col_adv,
  output logic [BYTE_W-1:0]          vid_byte,
  output logic                       vid_valid,
  input  logic                       vid_ready,
  output logic [BYTE_W-1:0]          cpu_data,
  output logic                       cpu_valid
);
  import nds_pkg::*;

  logic [PHASES-1:0] ph, ph_nxt;
  logic [ADDR_W-1:0] next_addr, slot_addr;
  logic              slot_vid, slot_rd;

  nds_phase_ring #(.N(PHASES)) u_ring (
    .clk(clk), .rst_n(rst_n), .ph(ph), .ph_nxt(ph_nxt)
  );

  nds_slot_arbiter #(.ADDR_W(ADDR_W), .N(PHASES)) u_arb (
    .clk(clk), .rst_n(rst_n), .ph_nxt(ph_nxt),
    .nmi_active(nmi_active), .vid_want(vid_want),
    .vid_addr(vid_addr), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .acc_freq(acc_freq), .next_addr(next_addr), .slot_addr(slot_addr),
    .slot_vid(slot_vid), .slot_rd(slot_rd)
  );

  nds_addr_strobe #(.ADDR_W(ADDR_W), .COL_BITS(COL_BITS), .N(PHASES), .DA_W(DA_W)) u_adr (
    .clk(clk), .rst_n(rst_n), .ph_nxt(ph_nxt),
    .next_addr(next_addr), .slot_addr(slot_addr),
    .dram_addr(dram_addr), .row_sel(row_sel), .col_sel(col_sel)
  );

  nds_byte_assembler #(.N(PHASES), .NIB_W(NIB_W), .BYTE_W(BYTE_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .ph_nxt(ph_nxt), .dram_dq(dram_dq),
    .slot_vid(slot_vid), .slot_rd(slot_rd), .vid_ready(vid_ready),
    .vid_byte(vid_byte), .vid_valid(vid_valid), .col_adv(col_adv),
    .cpu_data(cpu_data), .cpu_valid(cpu_valid)
  );

  a_r3_col_inside_row: assert property (@(posedge clk) disable iff (!rst_n)
    col_sel |-> row_sel);
  a_r3_row_closed_phase0: assert property (@(posedge clk) disable iff (!rst_n)
    ph[PH_ROW] |-> !row_sel && !col_sel);
  a_r7_adv_phase6: assert property (@(posedge clk) disable iff (!rst_n)
    col_adv |-> ph[PH_LO]);
  a_r9_cpu_phase6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> ph[PH_LO]);
endmodule

// File: tb/sim_nibble_dram_seq.sv
`timescale 1ns/1ps
module sim_nibble_dram_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] vid_addr = '0, cpu_addr = '0;
  logic        vid_want = 1'b0, nmi_active = 1'b0, cpu_rd = 1'b0, vid_ready = 1'b1;
  logic [2:0]  acc_freq = 3'd1;
  logic [3:0]  dram_dq;
  logic [8:0]  dram_addr;
  logic        row_sel, col_sel, col_adv, vid_valid, cpu_valid;
  logic [7:0]  vid_byte, cpu_data;

  always #5 clk = ~clk;

  nibble_dram_seq u0 (
    .clk(clk), .rst_n(rst_n), .vid_addr(vid_addr), .vid_want(vid_want),
    .nmi_active(nmi_active), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .acc_freq(acc_freq), .dram_dq(dram_dq), .dram_addr(dram_addr),
    .row_sel(row_sel), .col_sel(col_sel), .col_adv(col_adv),
    .vid_byte(vid_byte), .vid_valid(vid_valid), .vid_ready(vid_ready),
    .cpu_data(cpu_data), .cpu_valid(cpu_valid)
  );

  // memory model: address latches transparent while their strobe is low
  function automatic logic [3:0] nib(input logic [8:0] r, input logic [7:0] c);
    return r[3:0] ^ r[7:4] ^ {3'b0, r[8]} ^ c[3:0] ^ {c[6:4], c[7]};
  endfunction
  logic [8:0] row_q = '0, col_q = '0;
  always @(posedge clk) begin
    if (!row_sel) row_q <= dram_addr;
    if (!col_sel) col_q <= dram_addr;
  end
  assign dram_dq = nib(row_q, col_q[7:0]);

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  endtask

  // bench model state
  int         m_cnt = 0;
  bit         m_vv = 0;
  logic [7:0] m_vb = '0, m_cd = '0;

  function automatic int effq(input logic [2:0] f);
    return (f == 3'd2 || f == 3'd4) ? int'(f) : 1;
  endfunction

  // stimulus word: {nmi, want, rd, freq[2:0], vaddr[15:0], caddr[15:0]}
  localparam int NV = 12;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0,1'b1,1'b1,3'd1,16'h3000,16'h1234},
    {1'b0,1'b1,1'b1,3'd2,16'h3008,16'h1235},
    {1'b0,1'b1,1'b1,3'd2,16'h3010,16'h4567},
    {1'b1,1'b1,1'b1,3'd2,16'h3010,16'h89AB},
    {1'b0,1'b1,1'b0,3'd2,16'h3018,16'h0F0F},
    {1'b0,1'b0,1'b1,3'd4,16'h3018,16'h7FFF},
    {1'b0,1'b1,1'b1,3'd4,16'h3018,16'h0080},
    {1'b0,1'b1,1'b1,3'd4,16'h3018,16'hFF80},
    {1'b0,1'b1,1'b1,3'd4,16'h3018,16'h0001},
    {1'b0,1'b1,1'b1,3'd4,16'h7FFF,16'h2222},
    {1'b0,1'b1,1'b1,3'd3,16'h1111,16'h3333},
    {1'b0,1'b1,1'b1,3'd0,16'h5A5A,16'h0000}
  };

  task automatic drive(input logic [37:0] v);
    nmi_active = v[37]; vid_want = v[36]; cpu_rd = v[35];
    acc_freq = v[34:32]; vid_addr = v[31:16]; cpu_addr = v[15:0];
  endtask

  // called at a negedge in phase 7; runs one full slot and checks every phase
  task automatic run_slot(input logic [37:0] v);
    bit         own_vid;
    logic [15:0] a;
    logic [7:0]  exp_b;
    bit          rdy;
    drive(v);
    own_vid = !v[37] && v[36] && (m_cnt == 0);                 // R5
    a = own_vid ? v[31:16] : v[15:0];
    exp_b = {nib(a[15:7], {a[6:0],1'b0}), nib(a[15:7], {a[6:0],1'b1})}; // R4
    for (int p = 0; p < 8; p++) begin
      @(posedge clk);
      rdy = vid_ready;
      @(negedge clk);
      if (m_vv && rdy) m_vv = 0;                                // R8
      if (p == 6 && own_vid) begin m_vv = 1; m_vb = exp_b; end  // R7
      if (p == 6 && !own_vid && v[35]) m_cd = exp_b;            // R9
      if (p == 7) m_cnt = (m_cnt + 1 >= effq(v[34:32])) ? 0 : m_cnt + 1; // R6
      // R2 address per phase
      if (p == 0)      chk("R2", "row addr", dram_addr, {7'b0, a[15:7]});
      else if (p < 4)  chk("R2", "col0 addr", dram_addr, {1'b0, a[6:0], 1'b0});
      else if (p < 7)  chk("R2", "col1 addr", dram_addr, {1'b0, a[6:0], 1'b1});
      // R3 strobes (also proves R1 phase stepping)
      chk("R3", "row_sel", row_sel, (p >= 1 && p <= 6));
      chk("R3", "col_sel", col_sel, (p == 2 || p == 3 || p == 5 || p == 6));
      chk("R7", "col_adv", col_adv, (p == 6 && own_vid));
      chk("R8", "vid_valid", vid_valid, m_vv);
      if (m_vv) chk("R4", "vid_byte", vid_byte, m_vb);
      chk("R9", "cpu_valid", cpu_valid, (p == 6 && !own_vid && v[35]));
      chk("R9", "cpu_data", cpu_data, m_cd);
      // R5/R6: scramble everything mid-slot, restore before the phase-7 edge
      if (p == 2) drive(~v);
      if (p == 6) drive(v);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10", "row_sel", row_sel, 0);
    chk("R10", "col_sel", col_sel, 0);
    chk("R10", "dram_addr", dram_addr, 0);
    chk("R10", "vid_valid", vid_valid, 0);
    chk("R10", "cpu_valid", cpu_valid, 0);
    chk("R10", "col_adv", col_adv, 0);
    rst_n = 1'b1;   // ring now in phase 7 (R1)

    for (int i = 0; i < NV; i++) run_slot(VEC[i]);

    // R8: back-pressure, second byte overwrites the unaccepted first
    vid_ready = 1'b0;
    run_slot({1'b0,1'b1,1'b0,3'd1,16'h2468,16'h0000});
    run_slot({1'b0,1'b1,1'b0,3'd1,16'h1357,16'h0000});
    vid_ready = 1'b1;
    run_slot({1'b1,1'b0,1'b0,3'd1,16'h0000,16'h0ACE});
    chk("R8", "valid cleared after accept", vid_valid, 0);

    // R10: reset mid-slot, counter restarts at zero
    run_slot({1'b0,1'b1,1'b1,3'd4,16'h4000,16'h0100});   // video, count -> 1
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10", "row_sel mid-slot reset", row_sel, 0);
    chk("R10", "col_sel mid-slot reset", col_sel, 0);
    chk("R10", "dram_addr mid-slot reset", dram_addr, 0);
    chk("R10", "vid_valid mid-slot reset", vid_valid, 0);
    chk("R10", "cpu_data mid-slot reset", cpu_data, 0);
    rst_n = 1'b1;
    m_cnt = 0; m_vv = 0; m_cd = '0;
    run_slot({1'b0,1'b1,1'b1,3'd4,16'h4321,16'h0200});   // must be video again
    run_slot({1'b0,1'b1,1'b1,3'd4,16'h4329,16'h0300});   // CPU
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    summary();
  end
endmodule